// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block is the bus-master sequencer that sits between an internal requester and a 32-bit external bus. The requester hands it one operand transfer of one, two or four bytes at any byte address. The width of the device that answers is not known in advance: it is reported by the device on each cycle's termination. The controller then runs as many external bus cycles as the operand needs, moving the address forward and reporting the remaining byte count on every cycle.

Write data is copied onto several byte lanes at once, so that a narrow port finds its byte on the lanes it samples. Read data is collected from the lanes the answering port uses and packed into the operand. The result is returned right-justified with a one-cycle done pulse. Every cycle also carries three access qualifiers taken from the request: DMA or CPU origin, privilege level, and instruction or data access. A bus error ends the sequence at once and gives an error pulse in place of done.

Top module: `dbs_bus_master`

## Requirements
- R1: While reset is held and after it is released with no request, `busy`, `bus_strobe`, `done`, `err` and `bus_write` are all low.
- R2: A request is taken only when the block is idle. A `req_valid` raised while a transfer is in progress changes neither the bus address nor the size output, and it starts no bus cycle after that transfer ends.
- R3: Each bus cycle begins with one clock in which the address is driven and `bus_strobe` is low. `bus_strobe` is then high until the cycle is terminated, and the address holds steady meanwhile. The shortest cycle therefore takes two clocks.
- R4: `bus_ack` value 00 means wait. 01 ends the cycle as an 8-bit port, 10 as a 16-bit port and 11 as a 32-bit port. `bus_sterm` ends the cycle as a 32-bit port with synchronous termination.
- R5: On each termination, the remaining count and the address both change by the smaller of the bytes still owed and (port width minus address mod port width). A new cycle follows until nothing is owed, so the number of cycles follows from this rule.
- R6: `bus_siz` shows the bytes still owed, modulo 4: 01 = 1, 10 = 2, 11 = 3, 00 = 4. The request size code in `req_size` is 00 = 1 byte, 01 = 2 bytes, 1x = 4 bytes. A value in `req_wdata` is right-justified.
- R7: Byte lane k is `bus_wdata[31-8k -: 8]`. On a write, the next byte owed appears on lane 0, on lane (address bit 0), and on lane (address bits 1:0). Following bytes sit in address order on the lanes after these. An 8-bit, 16-bit or 32-bit port therefore finds every byte it takes.
- R8: On a read, the byte at address A is taken from lane 0 for an 8-bit port, from lane A[0] for a 16-bit port, and from lane A[1:0] for a 32-bit port. The bytes are assembled in address order with the lowest address most significant and returned right-justified in `rdata`.
- R9: `done` is high for exactly one clock, in the clock after the final termination, with `rdata` valid, and the block is idle at that point.
- R10: `bus_berr` during a strobed cycle ends the transfer: `err` pulses for one clock, `done` stays low and the block goes idle. A bus error takes priority over an acknowledge in the same clock.
- R11: During a transfer, `bus_write`, `bus_dma`, `bus_super` and `bus_instr` equal the values of the accepted request and stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code |
| req_addr | input | 32 | Byte address of operand |
| req_wdata | input | 32 | Right-justified write operand |
| req_dma | input | 1 | Request comes from DMA engine |
| req_super | input | 1 | Supervisor privilege |
| req_instr | input | 1 | Instruction fetch |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished pulse |
| err | output | 1 | Transfer aborted by bus error pulse |
| rdata | output | 32 | Right-justified read operand |
| bus_addr | output | 32 | External address |
| bus_siz | output | 2 | Bytes still owed, modulo 4 |
| bus_strobe | output | 1 | Cycle strobe |
| bus_write | output | 1 | Write cycle |
| bus_wdata | output | 32 | Write data lanes |
| bus_dma | output | 1 | DMA-initiated qualifier |
| bus_super | output | 1 | Supervisor qualifier |
| bus_instr | output | 1 | Instruction-access qualifier |
| bus_rdata | input | 32 | Read data lanes |
| bus_ack | input | 2 | Acknowledge with port size |
| bus_sterm | input | 1 | Synchronous 32-bit termination |
| bus_berr | input | 1 | Bus error |

## Verification
A bus error and a size-reporting acknowledge can arrive in the same clock. The bench provokes this by driving `bus_ack` = 11 and `bus_berr` together on a strobed cycle, and expects an `err` pulse with no `done`. A second case drives the error on the second cycle of a split transfer, after an 8-bit acknowledge has already moved part of the operand. A fresh `req_valid` can also coincide with a wait state in the middle of a transfer. That case is judged by the address and size outputs holding their values, and by no stray cycle following the done pulse.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    localparam int DBS_AW    = 32;
    localparam int DBS_DW    = 32;
    localparam int DBS_LANES = DBS_DW / 8;
    localparam int DBS_CW    = $clog2(DBS_LANES) + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } dbs_state_e;

    typedef struct packed {
        dbs_state_e          st;
        logic [DBS_AW-1:0]   addr;
        logic [DBS_CW-1:0]   rem;
        logic [DBS_CW-1:0]   used;
        logic [DBS_CW-1:0]   total;
        logic                wr;
        logic [DBS_DW-1:0]   op;
        logic [DBS_DW-1:0]   acc;
        logic [2:0]          qual;
        logic                done;
        logic                err;
        logic [DBS_DW-1:0]   rdata;
    } dbs_regs_t;
endpackage

// File: rtl/dbs_step_calc.sv
module dbs_step_calc
    import dbs_pkg::*;
(
    input  logic [1:0]        ack,
    input  logic              sterm,
    input  logic [1:0]        a_lo,
    input  logic [DBS_CW-1:0] rem,
    output logic              hit,
    output logic [DBS_CW-1:0] step,
    output logic [1:0]        lane_base
);
    logic [DBS_CW-1:0] port_bytes;
    logic [DBS_CW-1:0] room;

    always_comb begin
        if (sterm) begin
            port_bytes = DBS_CW'(4);
        end else begin
            case (ack)
                2'b01:   port_bytes = DBS_CW'(1);
                2'b10:   port_bytes = DBS_CW'(2);
                2'b11:   port_bytes = DBS_CW'(4);
                default: port_bytes = '0;
            endcase
        end
        hit = (port_bytes != '0);
        case (port_bytes)
            DBS_CW'(1): begin
                room      = DBS_CW'(1);
                lane_base = 2'd0;
            end
            DBS_CW'(2): begin
                room      = DBS_CW'(2) - DBS_CW'(a_lo[0]);
                lane_base = {1'b0, a_lo[0]};
            end
            DBS_CW'(4): begin
                room      = DBS_CW'(4) - DBS_CW'(a_lo);
                lane_base = a_lo;
            end
            default: begin
                room      = '0;
                lane_base = 2'd0;
            end
        endcase
        step = (rem < room) ? rem : room;
    end
endmodule

// File: rtl/dbs_write_steer.sv
module dbs_write_steer
    import dbs_pkg::*;
(
    input  logic [DBS_DW-1:0] op,
    input  logic [1:0]        a_lo,
    output logic [DBS_DW-1:0] lanes
);
    logic [7:0] b [DBS_LANES];

    for (genvar i = 0; i < DBS_LANES; i++) begin : g_bytes
        assign b[i] = op[8*(DBS_LANES-1-i) +: 8];
    end

    always_comb begin
        lanes[31:24] = b[0];
        lanes[23:16] = a_lo[0] ? b[0] : b[1];
        case (a_lo)
            2'd0:    lanes[15:8] = b[2];
            2'd1:    lanes[15:8] = b[1];
            default: lanes[15:8] = b[0];
        endcase
        lanes[7:0] = b[~a_lo];
    end
endmodule

// File: rtl/dbs_read_merge.sv
module dbs_read_merge
    import dbs_pkg::*;
(
    input  logic [DBS_DW-1:0] acc_in,
    input  logic [DBS_DW-1:0] lanes,
    input  logic [1:0]        lane_base,
    input  logic [DBS_CW-1:0] step,
    input  logic [DBS_CW-1:0] used,
    output logic [DBS_DW-1:0] acc_out
);
    always_comb begin
        acc_out = acc_in;
        for (int i = 0; i < DBS_LANES; i++) begin
            int dst;
            int src;
            dst = int'(used) + i;
            src = int'(lane_base) + i;
            if (i < int'(step) && dst < DBS_LANES && src < DBS_LANES) begin
                acc_out[8*(DBS_LANES-1-dst) +: 8] = lanes[8*(DBS_LANES-1-src) +: 8];
            end
        end
    end
endmodule

// File: rtl/dbs_bus_master.sv
module dbs_bus_master
    import dbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [DBS_AW-1:0] req_addr,
    input  logic [DBS_DW-1:0] req_wdata,
    input  logic              req_dma,
    input  logic              req_super,
    input  logic              req_instr,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DBS_DW-1:0] rdata,
    output logic [DBS_AW-1:0] bus_addr,
    output logic [1:0]        bus_siz,
    output logic              bus_strobe,
    output logic              bus_write,
    output logic [DBS_DW-1:0] bus_wdata,
    output logic              bus_dma,
    output logic              bus_super,
    output logic              bus_instr,
    input  logic [DBS_DW-1:0] bus_rdata,
    input  logic [1:0]        bus_ack,
    input  logic              bus_sterm,
    input  logic              bus_berr
);
    dbs_regs_t regs_d, regs_q;

    logic              hit;
    logic [DBS_CW-1:0] step;
    logic [1:0]        lane_base;
    logic [DBS_DW-1:0] lanes_out;
    logic [DBS_DW-1:0] merged;
    logic [DBS_CW-1:0] req_bytes;

    dbs_step_calc u_step (
        .ack       (bus_ack),
        .sterm     (bus_sterm),
        .a_lo      (regs_q.addr[1:0]),
        .rem       (regs_q.rem),
        .hit       (hit),
        .step      (step),
        .lane_base (lane_base)
    );

    dbs_write_steer u_steer (
        .op    (regs_q.op),
        .a_lo  (regs_q.addr[1:0]),
        .lanes (lanes_out)
    );

    dbs_read_merge u_merge (
        .acc_in    (regs_q.acc),
        .lanes     (bus_rdata),
        .lane_base (lane_base),
        .step      (step),
        .used      (regs_q.used),
        .acc_out   (merged)
    );

    always_comb begin
        case (req_size)
            2'b00:   req_bytes = DBS_CW'(1);
            2'b01:   req_bytes = DBS_CW'(2);
            default: req_bytes = DBS_CW'(4);
        endcase
    end

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        regs_d.err  = 1'b0;
        case (regs_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    regs_d.st    = ST_ADDR;
                    regs_d.addr  = req_addr;
                    regs_d.rem   = req_bytes;
                    regs_d.total = req_bytes;
                    regs_d.used  = '0;
                    regs_d.wr    = req_write;
                    regs_d.op    = req_wdata << {(DBS_CW'(4) - req_bytes), 3'b000};
                    regs_d.acc   = '0;
                    regs_d.qual  = {req_dma, req_super, req_instr};
                end
            end
            ST_ADDR: begin
                regs_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (bus_berr) begin
                    regs_d.st  = ST_IDLE;
                    regs_d.err = 1'b1;
                end else if (hit) begin
                    regs_d.rem  = regs_q.rem - step;
                    regs_d.used = regs_q.used + step;
                    regs_d.addr = regs_q.addr + DBS_AW'(step);
                    regs_d.op   = regs_q.op << {step, 3'b000};
                    regs_d.acc  = merged;
                    if (regs_q.rem == step) begin
                        regs_d.st   = ST_IDLE;
                        regs_d.done = 1'b1;
                        if (!regs_q.wr) begin
                            regs_d.rdata = merged >> {(DBS_CW'(4) - regs_q.total), 3'b000};
                        end
                    end else begin
                        regs_d.st = ST_ADDR;
                    end
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q    <= '0;
            regs_q.st <= ST_IDLE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign busy       = (regs_q.st != ST_IDLE);
    assign done       = regs_q.done;
    assign err        = regs_q.err;
    assign rdata      = regs_q.rdata;
    assign bus_addr   = regs_q.addr;
    assign bus_siz    = regs_q.rem[1:0];
    assign bus_strobe = (regs_q.st == ST_DATA);
    assign bus_write  = busy & regs_q.wr;
    assign bus_wdata  = bus_write ? lanes_out : '0;
    assign bus_dma    = busy & regs_q.qual[2];
    assign bus_super  = busy & regs_q.qual[1];
    assign bus_instr  = busy & regs_q.qual[0];

    // R3: strobe rises only after an address phase inside the same transfer
    p_addr_phase_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_strobe) |-> $past(busy) && $stable(bus_addr));

    // R3, R4: a wait keeps the cycle open with an unchanged address
    p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && !hit && !bus_berr) |=> bus_strobe && $stable(bus_addr));

    // R5: a terminating step moves at least one byte and never more than owed
    p_step_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && hit) |-> (step != '0) && (step <= regs_q.rem));

    // R6: count owed stays in 1..4 while busy
    p_rem_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (regs_q.rem != '0) && (regs_q.rem <= DBS_CW'(4)));

    // R9: done only when idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !bus_strobe);

    // R10: result reported either as done or as error, never both
    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R11: qualifiers constant across a transfer
    p_qual_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable({bus_write, bus_dma, bus_super, bus_instr}));
endmodule

// File: tb/sim_dbs_bus_master.sv
module sim_dbs_bus_master;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam int NV = 14;
    // {wr, bytes, addr low, port bytes, waits, data}
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 3'd4, 2'd0, 3'd4, 2'd0, 32'h0},
        {1'b0, 3'd4, 2'd1, 3'd4, 2'd1, 32'h0},
        {1'b0, 3'd4, 2'd2, 3'd2, 2'd0, 32'h0},
        {1'b0, 3'd4, 2'd3, 3'd1, 2'd1, 32'h0},
        {1'b0, 3'd2, 2'd3, 3'd2, 2'd0, 32'h0},
        {1'b0, 3'd1, 2'd2, 3'd1, 2'd0, 32'h0},
        {1'b0, 3'd2, 2'd1, 3'd4, 2'd0, 32'h0},
        {1'b1, 3'd4, 2'd0, 3'd1, 2'd0, 32'hCAFE_F00D},
        {1'b1, 3'd4, 2'd1, 3'd2, 2'd1, 32'h1234_5678},
        {1'b1, 3'd2, 2'd3, 3'd4, 2'd0, 32'h0000_ABCD},
        {1'b1, 3'd4, 2'd2, 3'd4, 2'd0, 32'h8765_4321},
        {1'b1, 3'd1, 2'd3, 3'd2, 2'd0, 32'h0000_005A},
        {1'b1, 3'd2, 2'd1, 3'd2, 2'd2, 32'h0000_C3E1},
        {1'b0, 3'd4, 2'd2, 3'd4, 2'd2, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_dma = 1'b0, req_super = 1'b0, req_instr = 1'b0;
    logic        busy, done, err;
    logic [31:0] rdata, bus_addr, bus_wdata;
    logic [1:0]  bus_siz;
    logic        bus_strobe, bus_write, bus_dma, bus_super, bus_instr;
    logic [31:0] bus_rdata = '0;
    logic [1:0]  bus_ack = 2'b00;
    logic        bus_sterm = 1'b0, bus_berr = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mem [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbs_bus_master u0 (
        .clk, .rst_n, .req_valid, .req_write, .req_size, .req_addr, .req_wdata,
        .req_dma, .req_super, .req_instr, .busy, .done, .err, .rdata,
        .bus_addr, .bus_siz, .bus_strobe, .bus_write, .bus_wdata,
        .bus_dma, .bus_super, .bus_instr, .bus_rdata, .bus_ack, .bus_sterm, .bus_berr
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic respond(input int port, input bit st);
        int a, rem, room, nb, lane;
        a    = int'(bus_addr[2:0]);
        rem  = (bus_siz == 2'd0) ? 4 : int'(bus_siz);
        room = port - (a % port);
        nb   = (rem < room) ? rem : room;
        bus_rdata = 32'hEEEE_EEEE;
        if (!bus_write) begin
            for (int j = 0; j < port; j++) begin
                int base;
                base = (port == 1) ? a : (port == 2) ? (a & ~1) : (a & ~3);
                bus_rdata[8*(3-j) +: 8] = mem[base + j];
            end
        end else begin
            for (int k = 0; k < nb; k++) begin
                lane = (port == 1) ? 0 : (port == 2) ? ((a + k) & 1) : ((a + k) & 3);
                mem[a + k] = bus_wdata[8*(3-lane) +: 8];
            end
        end
        if (port == 4 && st) bus_sterm = 1'b1;
        else bus_ack = (port == 1) ? 2'b01 : (port == 2) ? 2'b10 : 2'b11;
    endtask

    task automatic start_req(input int idx, input logic wr, input int n, input int lo, input logic [31:0] wd);
        req_valid = 1'b1;
        req_write = wr;
        req_size  = (n == 1) ? 2'b00 : (n == 2) ? 2'b01 : 2'b10;
        req_addr  = BASE + 32'(lo);
        req_wdata = wd;
        {req_dma, req_super, req_instr} = 3'(idx);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_op(input int idx, input logic wr, input int n, input int lo, input int port,
                          input int waits, input logic [31:0] wd, output logic [31:0] got,
                          output int cyc, output bit fin_done);
        int wcnt = 0;
        bit first = 1'b1;
        cyc = 0; fin_done = 1'b0; got = '0;
        start_req(idx, wr, n, lo, wd);
        for (int g = 0; g < 80; g++) begin
            bus_ack = 2'b00; bus_sterm = 1'b0;
            if (done) begin fin_done = 1'b1; got = rdata; break; end
            if (err) break;
            if (bus_strobe) begin
                if (first) begin
                    chk(bus_addr == BASE + 32'(lo), "R5 first address", 64'(bus_addr), 64'(BASE + 32'(lo)));
                    chk(bus_siz == 2'(n), "R6 first size", 64'(bus_siz), 64'(2'(n)));
                    chk({bus_write, bus_dma, bus_super, bus_instr} == {wr, 3'(idx)}, "R11 qualifiers",
                        64'({bus_write, bus_dma, bus_super, bus_instr}), 64'({wr, 3'(idx)}));
                    first = 1'b0;
                end
                if (wcnt < waits) wcnt++;
                else begin
                    respond(port, waits == 0);
                    cyc++;
                    wcnt = 0;
                end
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] got, expd;
        int cyc, ecyc;
        bit fin;
        logic [7:0] emem [8];

        repeat (3) @(negedge clk);
        // R1: reset state
        chk({busy, bus_strobe, done, err, bus_write} == 5'b0, "R1 in reset",
            64'({busy, bus_strobe, done, err, bus_write}), 64'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({busy, bus_strobe, done, err, bus_write} == 5'b0, "R1 after reset",
            64'({busy, bus_strobe, done, err, bus_write}), 64'(0));

        for (int v = 0; v < NV; v++) begin
            logic wr; int n, lo, port, waits; logic [31:0] wd;
            wr = VEC[v][42]; n = int'(VEC[v][41:39]); lo = int'(VEC[v][38:37]);
            port = int'(VEC[v][36:34]); waits = int'(VEC[v][33:32]); wd = VEC[v][31:0];
            for (int i = 0; i < 8; i++) begin
                mem[i] = 8'(8'h30 + i * 17 + v);
                emem[i] = mem[i];
            end
            expd = '0;
            for (int k = 0; k < n; k++) expd = (expd << 8) | 32'(mem[lo + k]);
            for (int k = 0; k < n; k++) emem[lo + k] = wd[8*(n-1-k) +: 8];
            ecyc = 0;
            begin
                int r, a;
                r = n; a = lo;
                while (r > 0) begin
                    int room, s;
                    room = port - (a % port);
                    s = (r < room) ? r : room;
                    r -= s; a += s; ecyc++;
                end
            end
            run_op(v, wr, n, lo, port, waits, wd, got, cyc, fin);
            chk(fin, "R9 done pulse", 64'(fin), 64'(1));
            chk(cyc == ecyc, "R5 cycle count", 64'(cyc), 64'(ecyc));
            if (!wr) begin
                chk(got == expd, "R8 read assembly", 64'(got), 64'(expd));
            end else begin
                for (int i = 0; i < 8; i++)
                    chk(mem[i] == emem[i], "R7 write lanes", 64'(mem[i]), 64'(emem[i]));
            end
            @(negedge clk);
            chk(!done, "R9 single pulse", 64'(done), 64'(0));
        end

        // R3, R4: minimum two-clock cycle with synchronous termination
        start_req(0, 1'b0, 4, 0, '0);
        chk(!bus_strobe && busy, "R3 address phase", 64'({bus_strobe, busy}), 64'(2'b01));
        @(negedge clk);
        chk(bus_strobe, "R3 strobe phase", 64'(bus_strobe), 64'(1));
        bus_sterm = 1'b1; bus_rdata = 32'h1122_3344;
        @(negedge clk);
        bus_sterm = 1'b0;
        chk(done && rdata == 32'h1122_3344, "R4 sync termination", 64'({done, rdata}), 64'({1'b1, 32'h1122_3344}));

        // R10: bus error on the second cycle of a split read
        @(negedge clk);
        start_req(1, 1'b0, 4, 0, '0);
        @(negedge clk);
        bus_ack = 2'b01; bus_rdata = 32'hAA00_0000;
        @(negedge clk);
        bus_ack = 2'b00;
        @(negedge clk);
        bus_berr = 1'b1;
        @(negedge clk);
        bus_berr = 1'b0;
        chk(err && !done && !busy, "R10 abort", 64'({err, done, busy}), 64'(3'b100));
        @(negedge clk);
        chk(!err && !busy, "R10 err pulse", 64'({err, busy}), 64'(0));

        // R10: error and acknowledge in the same clock
        start_req(2, 1'b0, 2, 0, '0);
        @(negedge clk);
        bus_ack = 2'b11; bus_berr = 1'b1;
        @(negedge clk);
        bus_ack = 2'b00; bus_berr = 1'b0;
        chk(err && !done, "R10 error beats ack", 64'({err, done}), 64'(2'b10));

        // R2: request during a transfer is ignored
        @(negedge clk);
        start_req(3, 1'b1, 4, 0, 32'h0102_0304);
        @(negedge clk);
        req_valid = 1'b1; req_addr = BASE + 32'h40; req_size = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_addr == BASE && bus_siz == 2'b00, "R2 busy request ignored",
            64'({bus_addr, bus_siz}), 64'({BASE, 2'b00}));
        bus_sterm = 1'b1;
        @(negedge clk);
        bus_sterm = 1'b0;
        chk(done, "R2 transfer completes", 64'(done), 64'(1));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!busy && !bus_strobe, "R2 no stray cycle", 64'({busy, bus_strobe}), 64'(0));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule